// File: doc/BRIEF.md
# Transfer descriptor status writeback unit

This unit computes the updated control word of a host-controller transfer descriptor once the bus transaction for that descriptor has produced a result. Each cycle it can accept a descriptor: the 32-bit control word, the 32-bit token word, a 3-bit result code and the number of bytes actually moved. One clock later it presents the following:

- the rewritten control word;
- a completion class that tells the list walker what to do next;
- two interrupt request bits, one for interrupt-on-complete and one for short packet;
- a bus-error flag;
- the fields decoded from the token.

The unit does not run the bus transaction, does not access memory and does not follow queue links. It holds the status rules only:

- the actual length is written back in minus-one form;
- on success the retry-pending NAK bit is cleared;
- a short packet stops the queue element pointer from advancing;
- too many bytes on an IN is reported as babble together with stall;
- a timeout decrements a 2-bit retry counter, and the descriptor is retired when that counter reaches zero.

Top module: `td_status_update`

## Requirements
- R1: Outputs are registered. `out_valid` equals `in_valid` from one clock earlier, and every output holds zero after reset.
- R2: The token is decoded as follows, and each field is registered with the result:
  - `pid` = token[7:0];
  - `dev_addr` = token[14:8];
  - `endp` = token[18:15];
  - `max_len` = (token[31:21] + 1) mod 2048, so a field of all ones gives zero bytes.
- R3: If the active bit (control bit 23) is clear on input, the control word passes through unchanged. The class is skip (2'b10), and `irq` and `usb_err` are both zero.
- R4: On an active descriptor whose PID is not IN (0x69), OUT (0xE1) or SETUP (0x2D), the class is fatal (2'b11), the control word is unchanged and no interrupt is raised.
- R5: Result code 0 (success) has these effects:
  - bits 10:0 become (len - 1) mod 2048;
  - active and NAK (bit 19) are cleared;
  - `irq[0]` copies the interrupt-on-complete bit (bit 24);
  - the class is done (2'b00), unless R6 or R7 applies.
- R6: On success with short-packet detect (bit 29) set and len below `max_len`, the class is short (2'b01) and `irq[1]` is 1.
- R7: A successful IN with len above `max_len` is treated as babble. Bits 20 and 22 are set, active is cleared, `usb_err` is 1, `irq[0]` copies bit 24 and the class is skip.
- R8: Result code 1 (stall) sets bit 22. Result code 2 (babble) sets bits 20 and 22. Both clear active, set `usb_err`, copy bit 24 to `irq[0]` and give class skip.
- R9: Result code 3 (NAK) on a PID other than SETUP sets bit 19, leaves active and the counter as they were, and gives class skip with no error.
- R10: The retry rule applies to result codes 4 to 7, and to a NAK on SETUP (which also sets bit 19). It works as follows:
  - bit 18 is set;
  - a nonzero counter in bits 28:27 is decremented;
  - when the decrement reaches zero, active is cleared, `usb_err` is set and `irq[0]` copies bit 24;
  - a counter that is already zero stays zero and the descriptor stays active.
- R11: An active descriptor with a valid PID and the isochronous bit (25) set leaves with active cleared, whatever the result code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor and result present this cycle |
| ctrl_in | input | 32 | Descriptor control word before update |
| token_in | input | 32 | Descriptor token word |
| result | input | 3 | Transaction result code |
| xfer_len | input | 12 | Bytes actually transferred |
| out_valid | output | 1 | Outputs below belong to a descriptor |
| ctrl_out | output | 32 | Updated control word |
| cls | output | 2 | 00 done, 01 short, 10 skip, 11 fatal |
| irq | output | 2 | Bit 0 interrupt on complete, bit 1 short packet |
| usb_err | output | 1 | Descriptor retired with a bus error |
| pid | output | 8 | Decoded packet identifier |
| dev_addr | output | 7 | Decoded device address |
| endp | output | 4 | Decoded endpoint |
| max_len | output | 11 | Decoded maximum length in bytes |

## Verification
The hardest paths to reach are those that combine rules. The retry counter has to step down to exactly zero and retire the descriptor with the interrupt. A SETUP NAK has to fall into the retry path instead of the NAK path. A successful IN has to overrun a zero-byte maximum and turn into babble.

The bench reaches each of these by building token and control words field by field. It uses length values on either side of `max_len`, a maximum-length field of all ones, and counter values 0, 1 and 3. Every result is compared with an independent behavioural model on each clock.

// File: rtl/td_status_update.sv
module td_status_update (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] ctrl_in,
  input  logic [31:0] token_in,
  input  logic [2:0]  result,
  input  logic [11:0] xfer_len,
  output logic        out_valid,
  output logic [31:0] ctrl_out,
  output logic [1:0]  cls,
  output logic [1:0]  irq,
  output logic        usb_err,
  output logic [7:0]  pid,
  output logic [6:0]  dev_addr,
  output logic [3:0]  endp,
  output logic [10:0] max_len
);
  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_OUT   = 8'hE1;
  localparam logic [7:0] PID_SETUP = 8'h2D;
  localparam int B_TMO = 18, B_NAK = 19, B_BAB = 20, B_STL = 22, B_ACT = 23;
  localparam int B_IOC = 24, B_ISO = 25, B_SPD = 29;
  localparam logic [1:0] C_DONE = 2'b00, C_SHORT = 2'b01, C_SKIP = 2'b10, C_FATAL = 2'b11;

  logic [7:0]  t_pid;
  logic [10:0] t_max;
  logic        is_in, is_setup, pid_ok;

  assign t_pid    = token_in[7:0];
  assign t_max    = token_in[31:21] + 11'd1;
  assign is_in    = (t_pid == PID_IN);
  assign is_setup = (t_pid == PID_SETUP);
  assign pid_ok   = is_in || is_setup || (t_pid == PID_OUT);

  logic [31:0] c;
  logic [1:0]  k, q, cnt;
  logic        e, retry;

  always_comb begin
    c     = ctrl_in;
    k     = C_SKIP;
    q     = 2'b00;
    e     = 1'b0;
    retry = 1'b0;
    cnt   = ctrl_in[28:27];
    if (!ctrl_in[B_ACT]) begin
      k = C_SKIP;
    end else if (!pid_ok) begin
      k = C_FATAL;
    end else begin
      if (ctrl_in[B_ISO]) c[B_ACT] = 1'b0;
      case (result)
        3'd0: begin
          c[10:0]  = xfer_len[10:0] - 11'd1;
          c[B_ACT] = 1'b0;
          c[B_NAK] = 1'b0;
          q[0]     = ctrl_in[B_IOC];
          if (is_in && (xfer_len > {1'b0, t_max})) begin
            c[B_BAB] = 1'b1;
            c[B_STL] = 1'b1;
            e        = 1'b1;
          end else if (ctrl_in[B_SPD] && (xfer_len < {1'b0, t_max})) begin
            k    = C_SHORT;
            q[1] = 1'b1;
          end else begin
            k = C_DONE;
          end
        end
        3'd1: begin
          c[B_STL] = 1'b1;
          c[B_ACT] = 1'b0;
          e        = 1'b1;
          q[0]     = ctrl_in[B_IOC];
        end
        3'd2: begin
          c[B_BAB] = 1'b1;
          c[B_STL] = 1'b1;
          c[B_ACT] = 1'b0;
          e        = 1'b1;
          q[0]     = ctrl_in[B_IOC];
        end
        3'd3: begin
          c[B_NAK] = 1'b1;
          retry    = is_setup;
        end
        default: retry = 1'b1;
      endcase
      if (retry) begin
        c[B_TMO] = 1'b1;
        if (cnt != 2'd0) begin
          cnt = cnt - 2'd1;
          if (cnt == 2'd0) begin
            c[B_ACT] = 1'b0;
            e        = 1'b1;
            q[0]     = ctrl_in[B_IOC];
          end
        end
        c[28:27] = cnt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ctrl_out  <= '0;
      cls       <= C_DONE;
      irq       <= 2'b00;
      usb_err   <= 1'b0;
      pid       <= '0;
      dev_addr  <= '0;
      endp      <= '0;
      max_len   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ctrl_out <= c;
        cls      <= k;
        irq      <= q;
        usb_err  <= e;
        pid      <= t_pid;
        dev_addr <= token_in[14:8];
        endp     <= token_in[18:15];
        max_len  <= t_max;
      end
    end
  end
endmodule

// File: rtl/td_status_chk.sv
module td_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] ctrl_in,
  input logic [31:0] token_in,
  input logic [2:0]  result,
  input logic [11:0] xfer_len,
  input logic        out_valid,
  input logic [31:0] ctrl_out,
  input logic [1:0]  cls,
  input logic [1:0]  irq,
  input logic        usb_err,
  input logic [7:0]  pid,
  input logic [6:0]  dev_addr,
  input logic [3:0]  endp,
  input logic [10:0] max_len
);
  logic pid_known;
  assign pid_known = (token_in[7:0] == 8'h69) || (token_in[7:0] == 8'hE1) ||
                     (token_in[7:0] == 8'h2D);

  p_valid_pipe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_pipe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_decode_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (dev_addr == $past(token_in[14:8])) && (endp == $past(token_in[18:15])));
  p_inactive_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ctrl_in[23]) |=>
      (cls == 2'b10) && (ctrl_out == $past(ctrl_in)) && (irq == 2'b00) && !usb_err);
  p_done_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cls == 2'b00) |-> (!ctrl_out[23] && !ctrl_out[19]));
  p_short_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cls == 2'b01) |-> (irq[1] && ctrl_out[29]));
  p_err_retires_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && usb_err) |-> !ctrl_out[23]);
  p_iso_retire_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ctrl_in[23] && ctrl_in[25] && pid_known) |=> !ctrl_out[23]);
endmodule

bind td_status_update td_status_chk u_chk (.*);

// File: tb/sim_td_status_update.sv
module sim_td_status_update;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] ctrl_in = '0;
  logic [31:0] token_in = '0;
  logic [2:0]  result = '0;
  logic [11:0] xfer_len = '0;
  logic        out_valid;
  logic [31:0] ctrl_out;
  logic [1:0]  cls;
  logic [1:0]  irq;
  logic        usb_err;
  logic [7:0]  pid;
  logic [6:0]  dev_addr;
  logic [3:0]  endp;
  logic [10:0] max_len;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  typedef struct packed {
    logic [31:0] c;
    logic [1:0]  k;
    logic [1:0]  q;
    logic        e;
    logic [7:0]  p;
    logic [6:0]  d;
    logic [3:0]  ep;
    logic [10:0] m;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];

  td_status_update u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic exp_t model(logic [31:0] ci, logic [31:0] tk, logic [2:0] rs, logic [11:0] ln);
    exp_t x;
    int mx, cntv, l;
    bit retry;
    x.c = ci; x.k = 2'b10; x.q = 2'b00; x.e = 1'b0;
    x.p = tk[7:0]; x.d = tk[14:8]; x.ep = tk[18:15];
    mx = (int'(tk[31:21]) + 1) % 2048;
    x.m = mx[10:0];
    l = int'(ln);
    retry = 0;
    if (ci[23] == 1'b0) return x;
    if (!(x.p == 8'h69 || x.p == 8'hE1 || x.p == 8'h2D)) begin
      x.k = 2'b11;
      return x;
    end
    if (ci[25]) x.c[23] = 1'b0;
    if (rs == 3'd0) begin
      x.c[10:0] = 11'((l + 2047) % 2048);
      x.c[23] = 0; x.c[19] = 0; x.q[0] = ci[24];
      if (x.p == 8'h69 && l > mx) begin
        x.c[20] = 1; x.c[22] = 1; x.e = 1;
      end else if (ci[29] && l < mx) begin
        x.k = 2'b01; x.q[1] = 1;
      end else x.k = 2'b00;
    end else if (rs == 3'd1 || rs == 3'd2) begin
      x.c[22] = 1; if (rs == 3'd2) x.c[20] = 1;
      x.c[23] = 0; x.e = 1; x.q[0] = ci[24];
    end else if (rs == 3'd3) begin
      x.c[19] = 1;
      retry = (x.p == 8'h2D);
    end else retry = 1;
    if (retry) begin
      x.c[18] = 1;
      cntv = int'(ci[28:27]);
      if (cntv > 0) begin
        cntv = cntv - 1;
        if (cntv == 0) begin x.c[23] = 0; x.e = 1; x.q[0] = ci[24]; end
      end
      x.c[28:27] = 2'(cntv);
    end
    return x;
  endfunction

  always @(posedge clk) begin
    if (rst_n && in_valid) begin
      exp_q.push_back(model(ctrl_in, token_in, result, xfer_len));
      req_q.push_back(cur_req);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_q.size() > 0) begin
        exp_t x;
        string r;
        x = exp_q.pop_front();
        r = req_q.pop_front();
        checks++;
        if (!out_valid || ctrl_out !== x.c || cls !== x.k || irq !== x.q || usb_err !== x.e ||
            pid !== x.p || dev_addr !== x.d || endp !== x.ep || max_len !== x.m) begin
          errors++;
          $display("FAIL %s: got v=%0b ctrl=%h cls=%b irq=%b err=%b pid=%h dev=%h ep=%h max=%0d exp ctrl=%h cls=%b irq=%b err=%b pid=%h dev=%h ep=%h max=%0d",
                   r, out_valid, ctrl_out, cls, irq, usb_err, pid, dev_addr, endp, max_len,
                   x.c, x.k, x.q, x.e, x.p, x.d, x.ep, x.m);
        end
      end else begin
        checks++;
        if (out_valid !== 1'b0) begin
          errors++;
          $display("FAIL R1: idle cycle out_valid=%b exp 0", out_valid);
        end
      end
    end
  end

  function automatic logic [31:0] mk_tok(logic [7:0] p, logic [6:0] d, logic [3:0] ep, int mlen);
    logic [10:0] f;
    f = 11'((mlen + 2047) % 2048);
    return {f, 2'b00, ep, d, p};
  endfunction

  function automatic logic [31:0] mk_ctrl(bit act, bit ioc, bit iso, bit spd, int errc, bit nak);
    logic [31:0] w;
    w = 32'h0000_0123;
    w[23] = act; w[24] = ioc; w[25] = iso; w[29] = spd;
    w[28:27] = 2'(errc); w[19] = nak;
    return w;
  endfunction

  task automatic drive(string r, logic [31:0] ci, logic [31:0] tk, logic [2:0] rs, int ln);
    @(negedge clk);
    cur_req  = r;
    ctrl_in  = ci;
    token_in = tk;
    result   = rs;
    xfer_len = 12'(ln);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0 || ctrl_out !== 0 || cls !== 0 || irq !== 0 || usb_err !== 0 || max_len !== 0) begin
      errors++;
      $display("FAIL R1: reset state v=%b ctrl=%h cls=%b irq=%b err=%b max=%0d exp all zero",
               out_valid, ctrl_out, cls, irq, usb_err, max_len);
    end
    rst_n = 1'b1;
    @(negedge clk);

    drive("R2",  mk_ctrl(1,0,0,0,3,0), mk_tok(8'hE1, 7'h5A, 4'hC, 64), 3'd0, 64);
    drive("R2",  mk_ctrl(1,0,0,0,3,0), mk_tok(8'hE1, 7'h01, 4'h3, 0), 3'd0, 0);
    drive("R5",  mk_ctrl(1,1,0,0,3,1), mk_tok(8'h69, 7'h11, 4'h1, 8), 3'd0, 8);
    drive("R5",  mk_ctrl(1,0,0,0,3,0), mk_tok(8'h69, 7'h11, 4'h1, 8), 3'd0, 0);
    drive("R6",  mk_ctrl(1,1,0,1,3,0), mk_tok(8'h69, 7'h22, 4'h2, 64), 3'd0, 13);
    drive("R6",  mk_ctrl(1,0,0,1,3,0), mk_tok(8'h69, 7'h22, 4'h2, 64), 3'd0, 64);
    drive("R7",  mk_ctrl(1,1,0,0,3,0), mk_tok(8'h69, 7'h22, 4'h2, 8), 3'd0, 9);
    drive("R7",  mk_ctrl(1,0,0,0,3,0), mk_tok(8'h69, 7'h22, 4'h2, 0), 3'd0, 1);
    drive("R7",  mk_ctrl(1,0,0,0,3,0), mk_tok(8'hE1, 7'h22, 4'h2, 8), 3'd0, 9);
    drive("R8",  mk_ctrl(1,1,0,0,3,0), mk_tok(8'hE1, 7'h33, 4'h4, 32), 3'd1, 0);
    drive("R8",  mk_ctrl(1,0,0,0,2,0), mk_tok(8'h69, 7'h33, 4'h4, 32), 3'd2, 0);
    drive("R9",  mk_ctrl(1,1,0,0,3,0), mk_tok(8'h69, 7'h44, 4'h5, 16), 3'd3, 0);
    drive("R10", mk_ctrl(1,1,0,0,3,0), mk_tok(8'h2D, 7'h44, 4'h0, 8), 3'd3, 0);
    drive("R10", mk_ctrl(1,1,0,0,3,0), mk_tok(8'hE1, 7'h44, 4'h5, 16), 3'd4, 0);
    drive("R10", mk_ctrl(1,1,0,0,1,0), mk_tok(8'hE1, 7'h44, 4'h5, 16), 3'd5, 0);
    drive("R10", mk_ctrl(1,1,0,0,0,0), mk_tok(8'h69, 7'h44, 4'h5, 16), 3'd4, 0);
    drive("R10", mk_ctrl(1,0,0,0,1,0), mk_tok(8'h2D, 7'h44, 4'h0, 8), 3'd7, 0);
    drive("R3",  mk_ctrl(0,1,0,1,3,1), mk_tok(8'h69, 7'h55, 4'h6, 8), 3'd0, 2);
    drive("R3",  mk_ctrl(0,1,1,0,1,0), mk_tok(8'hE1, 7'h55, 4'h6, 8), 3'd1, 2);
    drive("R4",  mk_ctrl(1,1,0,0,3,0), mk_tok(8'hA5, 7'h66, 4'h7, 8), 3'd0, 8);
    drive("R11", mk_ctrl(1,0,1,0,3,0), mk_tok(8'h69, 7'h77, 4'h8, 192), 3'd3, 0);
    drive("R11", mk_ctrl(1,1,1,0,3,0), mk_tok(8'hE1, 7'h77, 4'h8, 192), 3'd4, 0);
    drive("R11", mk_ctrl(1,1,1,1,3,0), mk_tok(8'h69, 7'h77, 4'h8, 192), 3'd0, 100);

    for (int i = 0; i < 8; i++) begin
      drive("R10", mk_ctrl(1, i[0], 0, i[1], i % 4, i[2]),
            mk_tok((i % 3 == 0) ? 8'h2D : 8'hE1, 7'(i), 4'(i), 4 * i), 3'(i), i);
    end

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule